// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a clocked host to an external asynchronous static RAM of 128K words by 8 bits. The host presents a request together with an address, a read/write select and write data. The controller latches these values and runs one access on the memory pins. At the end of the access it pulses an acknowledge and, for a read, updates a registered read-data output.

The memory side uses two chip selects that must both be active: an active-low enable and an active-high enable. It also drives active-low write and output strobes. The bidirectional data bus is split into an output value, an output-enable and an input value. Every phase length is a count of clock cycles. Each count is found by ceiling division of a nanosecond minimum from the memory's speed grade by the clock-period parameter. With the default 8 ns clock, a read holds the output strobe for 7 cycles. A write uses 1 setup cycle, a 6-cycle write strobe and 1 recovery cycle. After reset, the chip stays deselected for 7 cycles before the first request is taken.

Top module: `asram_ctrl`

## Requirements
- R1: After reset both chip selects are inactive (`mem_ce_n`=1, `mem_ce2`=0), both strobes are high, `mem_dq_oe`=0 and `ack`=0. A request held from reset release does not select the chip until 7 cycles have passed with the chip deselected.
- R2: In every cycle of an access, `mem_ce_n` is 0 and `mem_ce2` is 1. When no access is in progress, `mem_ce_n` is 1 and `mem_ce2` is 0.
- R3: A write keeps the chip selected for 8 cycles. `mem_we_n` is low for 6 consecutive cycles. The value written is the one stored at the memory when `mem_we_n` rises while the chip is still selected.
- R4: `mem_addr` and the written data are the values latched when the request was accepted. They do not change while the chip stays selected, even if the host inputs change during the access.
- R5: `mem_oe_n` stays high for the whole of a write. `mem_dq_oe` is 0 in the cycle `mem_we_n` falls. It is 1 in the remaining 5 strobe cycles and in the one cycle after `mem_we_n` rises, for 6 driven cycles in total. `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R6: A read keeps the chip selected, with `mem_oe_n` low and `mem_we_n` high, for 7 cycles. `rdata` takes the value of `mem_dq_in` at the end of the 7th cycle, so data that becomes valid only after the access time is still captured.
- R7: `ack` is high for exactly one cycle at the end of each access. A request still high during the acknowledge cycle does not start a new access.
- R8: `rdata` keeps the result of the last read across later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Registered read result |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Data arriving from memory |

## Verification
The hardest case to reach is a read that returns the correct value only because the controller waited long enough. The memory model in the bench returns the inverse of the stored byte until 7 output-strobe cycles have passed, so a read that captures early returns a wrong value. A similar guard applies to writes: the model stores a byte only if the controller drove it for at least 4 strobe cycles and the strobe rose while the chip was still selected. The model also tags each entry with the full address, so a wrong address cannot go unnoticed. Further directed tests scramble the host inputs in the middle of an access and leave the request high through the acknowledge cycle.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int CLK_NS = 8,
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_OE   = 30,
  parameter int T_WC   = 55,
  parameter int T_AW   = 50,
  parameter int T_CW   = 50,
  parameter int T_WP   = 45,
  parameter int T_DW   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_N   = mx(mx(cyc(T_RC), cyc(T_AA)), mx(cyc(T_OE), 1));
  localparam int WP_N   = mx(mx(mx(cyc(T_WP), cyc(T_DW) + 1), mx(cyc(T_AW) - 1, cyc(T_CW) - 1)),
                             mx(cyc(T_WC) - 2, 2));
  localparam int INIT_N = mx(cyc(T_RC), 1);
  localparam int CNT_W  = $clog2(mx(mx(RD_N, WP_N), INIT_N) + 1);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_RD, S_WSET, S_WSTB, S_WREC} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic             sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_INIT;
      cnt   <= CNT_W'(INIT_N - 1);
      ack   <= 1'b0;
      rdata <= '0;
      a_q   <= '0;
      d_q   <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_INIT: if (cnt == '0) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE: if (req && !ack) begin
          a_q <= addr;
          d_q <= wdata;
          if (wr) st <= S_WSET;
          else begin
            st  <= S_RD;
            cnt <= CNT_W'(RD_N - 1);
          end
        end
        S_RD: if (cnt == '0) begin
          rdata <= mem_dq_in;
          ack   <= 1'b1;
          st    <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WSET: begin
          st  <= S_WSTB;
          cnt <= CNT_W'(WP_N - 1);
        end
        S_WSTB: if (cnt == '0) st <= S_WREC; else cnt <= cnt - 1'b1;
        S_WREC: begin
          ack <= 1'b1;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel        = (st == S_RD) || (st == S_WSET) || (st == S_WSTB) || (st == S_WREC);
  assign mem_ce_n   = !sel;
  assign mem_ce2    = sel;
  assign mem_we_n   = (st != S_WSTB);
  assign mem_oe_n   = (st != S_RD);
  assign mem_addr   = a_q;
  assign mem_dq_out = d_q;
  assign mem_dq_oe  = ((st == S_WSTB) && (cnt != CNT_W'(WP_N - 1))) || (st == S_WREC);
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) !(mem_dq_oe && !mem_oe_n)); // R5
  AST_DRIVE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_we_n) |-> !mem_dq_oe); // R5
  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (!mem_ce_n && mem_ce2)); // R2
  AST_END_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (!mem_ce_n && mem_ce2 && mem_dq_oe)); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R4
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R7
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
  localparam int RD_EXP = 7;
  localparam int WP_EXP = 6;
  localparam int DW_MIN = 4;
  localparam int NV = 11;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 17'h1FFFF, 8'hC3},
    {1'b1, 17'h0ABCD, 8'h5A},
    {1'b0, 17'h00000, 8'h00},
    {1'b0, 17'h1FFFF, 8'h00},
    {1'b1, 17'h12345, 8'hA5},
    {1'b0, 17'h0ABCD, 8'h00},
    {1'b0, 17'h12345, 8'h00},
    {1'b1, 17'h00000, 8'hFF},
    {1'b0, 17'h00000, 8'h00},
    {1'b1, 17'h10001, 8'h00},
    {1'b0, 17'h10001, 8'h00}
  };

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [16:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ack, mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  logic        m_v   [64];
  logic [16:0] m_tag [64];
  logic [7:0]  m_dat [64];
  logic        e_v   [64];
  logic [7:0]  e_dat [64];
  int rd_run = 0, wrun = 0;
  logic prev_we = 1'b1;
  logic [7:0] wlat = '0;
  wire msel = !mem_ce_n && mem_ce2;
  wire [5:0] mi = mem_addr[5:0];

  initial for (int i = 0; i < 64; i++) begin m_v[i] = 0; e_v[i] = 0; m_tag[i] = '0; m_dat[i] = '0; e_dat[i] = '0; end

  always @(negedge clk) begin
    if (msel && !mem_oe_n && mem_we_n) rd_run = rd_run + 1; else rd_run = 0;
    if (!mem_we_n) begin
      if (msel && mem_dq_oe) begin wlat = mem_dq_out; wrun = wrun + 1; end
    end else begin
      if (!prev_we && msel && wrun >= DW_MIN) begin
        m_v[mi] = 1'b1; m_tag[mi] = mem_addr; m_dat[mi] = wlat;
      end
      wrun = 0;
    end
    prev_we = mem_we_n;
  end

  assign mem_dq_in = (m_v[mi] && m_tag[mi] == mem_addr) ?
                     ((rd_run >= RD_EXP) ? m_dat[mi] : ~m_dat[mi]) : 8'hEE;

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [16:0] a, input logic [7:0] d,
                      input bit hold, input bit scramble);
    int n = 0, n_sel = 0, n_we = 0, n_oe = 0, n_dq = 0, n_bad = 0;
    bit got = 0;
    logic [7:0] r_before;
    r_before = rdata;
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    while (!got && n < 200) begin
      @(negedge clk);
      n++;
      if (scramble && n == 2) begin addr = ~a; wdata = ~d; wr = !w; end
      if (ack) got = 1;
      else begin
        if (msel) n_sel++;
        if (mem_ce_n == mem_ce2) n_bad++;
        if (!mem_we_n) n_we++;
        if (!mem_oe_n) n_oe++;
        if (mem_dq_oe) n_dq++;
      end
    end
    check(got, "R7 ack seen", got, 1);
    check(n_bad == 0, "R2 select pair", n_bad, 0);
    if (w) begin
      check(n_sel == 8, "R3 write select cycles", n_sel, 8);
      check(n_we == WP_EXP, "R3 strobe cycles", n_we, WP_EXP);
      check(n_oe == 0, "R5 oe high in write", n_oe, 0);
      check(n_dq == WP_EXP, "R5 driven cycles", n_dq, WP_EXP);
      check(rdata == r_before, "R8 rdata held", rdata, r_before);
      e_v[a[5:0]] = 1; e_dat[a[5:0]] = d;
    end else begin
      check(n_sel == RD_EXP, "R6 read select cycles", n_sel, RD_EXP);
      check(n_oe == RD_EXP && n_we == 0 && n_dq == 0, "R6 read strobes", n_oe, RD_EXP);
      check(rdata == e_dat[a[5:0]], "R6 read data", rdata, e_dat[a[5:0]]);
    end
    if (hold) begin
      @(negedge clk);
      check(mem_ce_n && !mem_ce2, "R7 no restart in ack cycle", mem_ce_n, 1);
    end
    req = 0; wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pre = 0;
    bit sel_seen = 0;
    req = 1; wr = 1; addr = 17'h00000; wdata = 8'h3C;
    #20;
    check(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !ack,
          "R1 reset outputs", {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, ack}, 6'b101100);
    @(negedge clk); rst_n = 1;
    while (!sel_seen && pre < 50) begin
      @(negedge clk);
      if (msel) sel_seen = 1; else pre++;
    end
    check(pre == RD_EXP, "R1 recovery cycles", pre, RD_EXP);
    while (!ack && pre < 100) begin @(negedge clk); pre++; end
    req = 0;
    e_v[0] = 1; e_dat[0] = 8'h3C;

    for (int i = 0; i < NV; i++)
      xfer(VEC[i][25], VEC[i][24:8], VEC[i][7:0], 0, 0);

    xfer(1'b1, 17'h05432, 8'h96, 0, 1);   // R4 inputs scrambled mid-write
    xfer(1'b0, 17'h05432, 8'h00, 0, 1);   // R4 inputs scrambled mid-read
    xfer(1'b1, 17'h0F0F0, 8'h3E, 1, 0);   // R7 req held into ack cycle
    xfer(1'b0, 17'h0F0F0, 8'h00, 1, 0);
    xfer(1'b1, 17'h0AAAA, 8'h11, 0, 0);   // R8 rdata kept across write
    check(rdata == 8'h3E, "R8 rdata after write", rdata, 8'h3E);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule